// File: doc/BRIEF.md
# Bus Idle-Time Start Scheduler

This block decides when a CEC transmitter may begin driving the start bit of a new frame. It measures how long the shared line has been quiet. It does this by counting ticks that arrive at twice the nominal data bit rate, so every wait is a whole number of half-bit steps. Any activity on the line clears the count. When a transmit request is pending, the line is idle and the required quiet time has passed, the block emits a one-cycle grant on the next tick.

The required quiet time comes from a 3-bit code.
- Codes 1 to 7 give a fixed wait of 0.5, 1.5, and so on up to 6.5 bit periods.
- Code 0 picks a wait from the history of the previous frame: a long wait after a failed transmission, a medium wait when this node takes the line after another sender, and a short wait when this node follows its own successful frame.

A start-option input selects when the count restarts.
- With the option at 0, the count restarts when software raises its start request.
- With the option at 1, the count restarts at the end of any frame, sent or received.

A second output marks a grant whose first byte is also the last byte of the message.

Top module: `sft_sched`

## Requirements
- R1: While reset is asserted, both outputs are low. After reset, the last-frame history is "other sender". With code 0 and start option 0, the grant therefore follows 11 ticks after the request rises.
- R2: With start option 0 and code n in 1..7, the count restarts when `som_req_i` rises. The grant appears on the tick that follows 2n−1 counted ticks, which is the (2n)-th tick after the rise.
- R3: With code 0, the wait is 14 half-bit ticks after a `tx_fail_i` pulse, 6 after a `tx_done_i` pulse, and 10 after an `rx_done_i` pulse. The grant therefore lands on tick 15, 7 or 11 after the restart.
- R4: A cycle with `bus_idle_i` low clears the count. No grant is issued while the line is busy, and the full wait is counted again once the line is idle.
- R5: With start option 1, the count restarts on any end-of-frame pulse and runs whether or not a request is pending. A request that rises after the wait has elapsed is granted on the next tick.
- R6: With start option 1 and the request already high at the end-of-frame pulse, the grant appears on the tick that follows the full wait for the selected code.
- R7: With start option 0, end-of-frame pulses neither start nor restart the count. Only a rising request does.
- R8: Each request yields exactly one single-cycle grant. No grant occurs without a request, and a further grant needs the request to fall and rise again.
- R9: `grant_single_o` is high together with `grant_o` exactly when `eom_req_i` is high at the granting tick. A one-byte message must present its end-of-message request no later than its start request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| half_tick_i | input | 1 | One-cycle strobe at twice the nominal bit rate |
| bus_idle_i | input | 1 | High while the line is free of activity |
| sft_code_i | input | CODE_W | Quiet-time code (0 = history-based default) |
| start_opt_i | input | 1 | 0: count restarts on request; 1: count restarts at frame end |
| som_req_i | input | 1 | Start-of-message request (level) |
| eom_req_i | input | 1 | End-of-message request (level) |
| tx_done_i | input | 1 | Pulse: own transmission ended successfully |
| tx_fail_i | input | 1 | Pulse: own transmission ended with an error |
| rx_done_i | input | 1 | Pulse: reception of another sender's frame ended |
| grant_o | output | 1 | One-cycle permission to send the start bit |
| grant_single_o | output | 1 | Grant for a message whose first byte is its last |

## Verification
The assertions assume the following about the inputs:
- `half_tick_i` is a single-cycle strobe with at least one idle cycle between strobes.
- A request edge or an end-of-frame pulse never coincides with a tick.
- The request stays high until a grant has been seen.

The bench keeps to these rules by spacing ticks four cycles apart. It changes every other input only on falling edges and only in cycles without a tick. It sweeps every code in both start options, and for code 0 it walks each of the three frame histories, counting ticks from restart to grant.

// File: rtl/sft_pkg.sv
package sft_pkg;

   // History of the frame that last occupied the line
   typedef enum logic [1:0] {
      PREV_OTHER = 2'd0,   // another node sent it
      PREV_SELF  = 2'd1,   // this node sent it successfully
      PREV_FAIL  = 2'd2    // this node's transmission failed
   } prev_frame_e;

endpackage

// File: rtl/sft_history.sv
module sft_history
   import sft_pkg::*;
(
   input  logic        clk,
   input  logic        rst_n,
   input  logic        tx_done_i,
   input  logic        tx_fail_i,
   input  logic        rx_done_i,
   output prev_frame_e prev_o
);

   prev_frame_e prev_q;

   // Failure dominates success, success dominates reception
   always_ff @(posedge clk) begin
      if (!rst_n)          prev_q <= PREV_OTHER;
      else if (tx_fail_i)  prev_q <= PREV_FAIL;
      else if (tx_done_i)  prev_q <= PREV_SELF;
      else if (rx_done_i)  prev_q <= PREV_OTHER;
   end

   assign prev_o = prev_q;

   AST_FAIL_RECORDED: assert property (@(posedge clk) disable iff (!rst_n)
      tx_fail_i |=> (prev_q == PREV_FAIL)); // R3

endmodule

// File: rtl/sft_wait_lut.sv
module sft_wait_lut
   import sft_pkg::*;
#(
   parameter int CODE_W        = 3,
   parameter int DEF_FAIL_BITS = 7,
   parameter int DEF_NEW_BITS  = 5,
   parameter int DEF_SAME_BITS = 3,
   parameter int TGT_W         = 4
)(
   input  logic [CODE_W-1:0] code_i,
   input  prev_frame_e       prev_i,
   output logic [TGT_W-1:0]  target_o
);

   localparam int NCODES = 1 << CODE_W;

   logic [TGT_W-1:0] lut [NCODES];

   // Fixed codes: 0.5 + (n-1) bit periods = 2n-1 half-bit ticks
   for (genvar g = 1; g < NCODES; g++) begin : g_fixed
      assign lut[g] = TGT_W'(2 * g - 1);
   end

   // Code 0: wait chosen by the previous frame
   always_comb begin
      case (prev_i)
         PREV_FAIL: lut[0] = TGT_W'(2 * DEF_FAIL_BITS);
         PREV_SELF: lut[0] = TGT_W'(2 * DEF_SAME_BITS);
         default:   lut[0] = TGT_W'(2 * DEF_NEW_BITS);
      endcase
   end

   assign target_o = lut[code_i];

endmodule

// File: rtl/sft_counter.sv
module sft_counter #(
   parameter int CNT_W = 4
)(
   input  logic             clk,
   input  logic             rst_n,
   input  logic             tick_i,
   input  logic             bus_idle_i,
   input  logic             restart_i,
   input  logic [CNT_W-1:0] target_i,
   output logic             expired_o
);

   localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

   logic [CNT_W-1:0] cnt_q;

   always_ff @(posedge clk) begin
      if (!rst_n)                          cnt_q <= '0;
      else if (restart_i || !bus_idle_i)   cnt_q <= '0;
      else if (tick_i && cnt_q != CNT_MAX) cnt_q <= cnt_q + 1'b1;
   end

   assign expired_o = (cnt_q >= target_i);

   AST_BUSY_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
      !bus_idle_i |=> (cnt_q == '0)); // R4
   AST_RESTART_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
      restart_i |=> (cnt_q == '0)); // R5
   AST_NO_TICK_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (!tick_i && bus_idle_i && !restart_i) |=> $stable(cnt_q)); // R2

endmodule

// File: rtl/sft_sched.sv
module sft_sched
   import sft_pkg::*;
#(
   parameter int CODE_W        = 3,
   parameter int DEF_FAIL_BITS = 7,
   parameter int DEF_NEW_BITS  = 5,
   parameter int DEF_SAME_BITS = 3
)(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              half_tick_i,
   input  logic              bus_idle_i,
   input  logic [CODE_W-1:0] sft_code_i,
   input  logic              start_opt_i,
   input  logic              som_req_i,
   input  logic              eom_req_i,
   input  logic              tx_done_i,
   input  logic              tx_fail_i,
   input  logic              rx_done_i,
   output logic              grant_o,
   output logic              grant_single_o
);

   localparam int CODE_MAX_TGT = 2 * ((1 << CODE_W) - 1) - 1;
   localparam int DEF_MAX_BITS = (DEF_FAIL_BITS > DEF_NEW_BITS) ?
                                 ((DEF_FAIL_BITS > DEF_SAME_BITS) ? DEF_FAIL_BITS : DEF_SAME_BITS) :
                                 ((DEF_NEW_BITS > DEF_SAME_BITS) ? DEF_NEW_BITS : DEF_SAME_BITS);
   localparam int TGT_MAX      = (CODE_MAX_TGT > 2 * DEF_MAX_BITS) ? CODE_MAX_TGT : 2 * DEF_MAX_BITS;
   localparam int CNT_W        = $clog2(TGT_MAX + 1);

   initial begin : p_param_chk
      assert (CODE_W >= 1 && CODE_W <= 6)
         else $error("CODE_W out of range");
      assert (DEF_SAME_BITS >= 1 && DEF_NEW_BITS >= DEF_SAME_BITS && DEF_FAIL_BITS >= DEF_NEW_BITS)
         else $error("default waits must be ordered fail >= new >= same >= 1");
   end

   prev_frame_e      prev;
   logic [CNT_W-1:0] target;
   logic             expired;
   logic             som_prev_q;
   logic             som_rise;
   logic             frame_end;
   logic             restart;
   logic             issued_q;
   logic             grant_q;
   logic             single_q;
   logic             grant_now;

   sft_history u_hist (
      .clk       (clk),
      .rst_n     (rst_n),
      .tx_done_i (tx_done_i),
      .tx_fail_i (tx_fail_i),
      .rx_done_i (rx_done_i),
      .prev_o    (prev)
   );

   sft_wait_lut #(
      .CODE_W        (CODE_W),
      .DEF_FAIL_BITS (DEF_FAIL_BITS),
      .DEF_NEW_BITS  (DEF_NEW_BITS),
      .DEF_SAME_BITS (DEF_SAME_BITS),
      .TGT_W         (CNT_W)
   ) u_lut (
      .code_i   (sft_code_i),
      .prev_i   (prev),
      .target_o (target)
   );

   assign som_rise  = som_req_i && !som_prev_q;
   assign frame_end = tx_done_i || tx_fail_i || rx_done_i;
   assign restart   = start_opt_i ? frame_end : som_rise;

   sft_counter #(
      .CNT_W (CNT_W)
   ) u_cnt (
      .clk        (clk),
      .rst_n      (rst_n),
      .tick_i     (half_tick_i),
      .bus_idle_i (bus_idle_i),
      .restart_i  (restart),
      .target_i   (target),
      .expired_o  (expired)
   );

   assign grant_now = half_tick_i && som_req_i && !issued_q && bus_idle_i
                      && expired && !restart;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         som_prev_q <= 1'b0;
         issued_q   <= 1'b0;
         grant_q    <= 1'b0;
         single_q   <= 1'b0;
      end else begin
         som_prev_q <= som_req_i;
         grant_q    <= grant_now;
         single_q   <= grant_now && eom_req_i;
         if (!som_req_i)     issued_q <= 1'b0;
         else if (grant_now) issued_q <= 1'b1;
      end
   end

   assign grant_o        = grant_q;
   assign grant_single_o = single_q;

   AST_GRANT_NEEDS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
      grant_o |-> $past(som_req_i)); // R8
   AST_GRANT_ONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
      grant_o |=> !grant_o); // R8
   AST_GRANT_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      grant_o |-> $past(bus_idle_i)); // R4
   AST_GRANT_EXPIRED: assert property (@(posedge clk) disable iff (!rst_n)
      grant_o |-> $past(expired)); // R2
   AST_GRANT_ON_TICK: assert property (@(posedge clk) disable iff (!rst_n)
      grant_o |-> $past(half_tick_i)); // R5
   AST_SINGLE_WITH_EOM: assert property (@(posedge clk) disable iff (!rst_n)
      grant_single_o |-> (grant_o && $past(eom_req_i))); // R9

endmodule

// File: tb/sft_sched_tb.sv
module sft_sched_tb;

   localparam int CLK_PERIOD = 10;
   localparam int LIM        = 40;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       half_tick = 1'b0;
   logic       bus_idle = 1'b1;
   logic [2:0] sft_code = 3'd0;
   logic       start_opt = 1'b0;
   logic       som_req = 1'b0;
   logic       eom_req = 1'b0;
   logic       tx_done = 1'b0;
   logic       tx_fail = 1'b0;
   logic       rx_done = 1'b0;
   logic       grant_o;
   logic       grant_single_o;

   int n_checks = 0;
   int n_fail   = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   sft_sched u_dut (
      .clk            (clk),
      .rst_n          (rst_n),
      .half_tick_i    (half_tick),
      .bus_idle_i     (bus_idle),
      .sft_code_i     (sft_code),
      .start_opt_i    (start_opt),
      .som_req_i      (som_req),
      .eom_req_i      (eom_req),
      .tx_done_i      (tx_done),
      .tx_fail_i      (tx_fail),
      .rx_done_i      (rx_done),
      .grant_o        (grant_o),
      .grant_single_o (grant_single_o)
   );

   task automatic chk(input bit ok, input string tag, input int act, input int exp);
      n_checks++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   // One tick; returns the grant seen in the cycle after it
   task automatic do_tick(output bit g, output bit s);
      @(negedge clk) half_tick = 1'b1;
      @(negedge clk) half_tick = 1'b0;
      g = grant_o;
      s = grant_single_o;
      @(negedge clk);
      @(negedge clk);
   endtask

   task automatic ticks_to_grant(output int n, output bit s);
      bit g;
      bit sv;
      n = 0;
      s = 1'b0;
      for (int i = 1; i <= LIM; i++) begin
         do_tick(g, sv);
         if (g) begin
            n = i;
            s = sv;
            break;
         end
      end
   endtask

   task automatic count_grants(input int ticks, output int grants);
      bit g;
      bit s;
      grants = 0;
      for (int i = 0; i < ticks; i++) begin
         do_tick(g, s);
         if (g) grants++;
      end
   endtask

   task automatic raise_som();
      @(negedge clk) som_req = 1'b1;
      @(negedge clk);
   endtask

   task automatic drop_som();
      @(negedge clk) som_req = 1'b0;
      @(negedge clk);
   endtask

   // which: 0 = rx_done, 1 = tx_done, 2 = tx_fail
   task automatic end_pulse(input int which);
      @(negedge clk);
      case (which)
         0: rx_done = 1'b1;
         1: tx_done = 1'b1;
         default: tx_fail = 1'b1;
      endcase
      @(negedge clk);
      rx_done = 1'b0;
      tx_done = 1'b0;
      tx_fail = 1'b0;
   endtask

   initial begin : p_watchdog
      #(CLK_PERIOD * 200000);
      n_checks++;
      n_fail++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
   end

   initial begin : p_main
      int n;
      bit s;
      int gr;
      int expn[3];

      // R1: outputs low in reset
      repeat (3) @(negedge clk);
      chk(grant_o == 1'b0 && grant_single_o == 1'b0, "R1 reset outputs",
          int'(grant_o) + int'(grant_single_o), 0);
      @(negedge clk) rst_n = 1'b1;
      @(negedge clk);

      // R1/R3: history after reset is "other sender" -> 10 half ticks
      start_opt = 1'b0;
      sft_code  = 3'd0;
      raise_som();
      ticks_to_grant(n, s);
      chk(n == 11, "R1 default wait after reset", n, 11);
      drop_som();

      // R2 and R9: every fixed code, start option 0
      for (int c = 1; c < 8; c++) begin
         sft_code = 3'(c);
         eom_req  = c[0];
         raise_som();
         ticks_to_grant(n, s);
         chk(n == 2 * c, "R2 fixed code wait", n, 2 * c);
         chk(s == c[0], "R9 single-byte flag", int'(s), c[0]);
         drop_som();
      end
      eom_req = 1'b0;

      // R3: code 0 for each history
      expn[0] = 11; expn[1] = 7; expn[2] = 15;
      sft_code = 3'd0;
      for (int w = 0; w < 3; w++) begin
         end_pulse(w);
         raise_som();
         ticks_to_grant(n, s);
         chk(n == expn[w], "R3 default wait per history", n, expn[w]);
         drop_som();
      end

      // R4: line activity clears the count
      sft_code = 3'd3;
      raise_som();
      count_grants(3, gr);
      chk(gr == 0, "R4 no grant before wait", gr, 0);
      @(negedge clk) bus_idle = 1'b0;
      @(negedge clk) bus_idle = 1'b1;
      ticks_to_grant(n, s);
      chk(n == 6, "R4 full wait after activity", n, 6);
      drop_som();

      // R4: no grant while the line stays busy
      sft_code = 3'd1;
      raise_som();
      @(negedge clk) bus_idle = 1'b0;
      count_grants(6, gr);
      chk(gr == 0, "R4 no grant on busy line", gr, 0);
      @(negedge clk) bus_idle = 1'b1;
      ticks_to_grant(n, s);
      chk(n == 2, "R4 wait restarts once idle", n, 2);
      drop_som();

      // R8: one grant per request
      sft_code = 3'd1;
      raise_som();
      ticks_to_grant(n, s);
      chk(n == 2, "R8 first grant", n, 2);
      count_grants(10, gr);
      chk(gr == 0, "R8 no repeat while held", gr, 0);
      drop_som();
      count_grants(4, gr);
      chk(gr == 0, "R8 no grant without request", gr, 0);
      raise_som();
      ticks_to_grant(n, s);
      chk(n == 2, "R8 new request grants again", n, 2);
      drop_som();

      // R7: option 0 ignores end-of-frame pulses for counting
      sft_code = 3'd2;
      end_pulse(1);
      count_grants(20, gr);
      chk(gr == 0, "R7 no grant from frame end", gr, 0);
      raise_som();
      ticks_to_grant(n, s);
      chk(n == 4, "R7 count starts at request", n, 4);
      drop_som();
      sft_code = 3'd3;
      raise_som();
      count_grants(3, gr);
      end_pulse(0);
      ticks_to_grant(n, s);
      chk(n == 3, "R7 frame end does not restart", n, 3);
      drop_som();

      // R6: option 1 sweep, request pending at frame end
      start_opt = 1'b1;
      for (int c = 0; c < 8; c++) begin
         sft_code = 3'(c);
         end_pulse(0);
         raise_som();
         ticks_to_grant(n, s);
         chk(n == ((c == 0) ? 11 : 2 * c), "R6 option 1 wait", n, (c == 0) ? 11 : 2 * c);
         drop_som();
      end

      // R5: option 1, wait already elapsed when request arrives
      sft_code = 3'd2;
      end_pulse(0);
      count_grants(5, gr);
      chk(gr == 0, "R5 no grant before request", gr, 0);
      raise_som();
      ticks_to_grant(n, s);
      chk(n == 1, "R5 grant on next tick", n, 1);
      drop_som();

      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
   end

endmodule